// File: doc/BRIEF.md
# Pixel Hit Time-Stamp Recorder

This block holds the digital record of one pixel in a hit-stamping sensor array. A shared 14-bit time-stamp bus runs past every pixel. It counts at a few MHz. When the pixel's discriminator output goes from low to high, the block captures the bus value into the next free cell of a small local store and advances its write pointer. With the default two cells, a pixel that is hit twice before it is read keeps both stamps. A hit that arrives when every cell is full is discarded, and a sticky overflow flag records that it was lost.

For readout, a cell-select input routes one cell to the output together with that cell's valid bit. An empty flag is raised whenever the pixel holds no record, so that array-level sparse readout can skip the pixel at once. A read-clear strobe at the end of readout frees the store. For memory testing, a test mode lets an external strobe broadcast one value into every cell in the same cycle. Each cell can then be read back and compared with that value.

Top module: `ts_hit_recorder`

## Requirements
- R1: After reset, empty_o is 1, overflow_o is 0, and rd_valid_o and rd_data_o are 0 for every value of rd_sel_i.
- R2: On a clock edge where disc_i is 1 and was 0 at the previous edge, the value on ts_bus_i at that edge is stored in the first free cell (cell 0 after reset or clear) and that cell becomes valid.
- R3: A second recorded hit is stored in cell 1 and leaves the contents of cell 0 unchanged.
- R4: disc_i held high for several cycles records exactly one hit, with the bus value from its first high edge, while ts_bus_i changes during the pulse.
- R5: A hit that arrives while all cells are valid is dropped and leaves every cell unchanged. It sets overflow_o, which stays at 1 until a read-clear.
- R6: empty_o is 1 exactly when no cell is valid.
- R7: rd_sel_i selects the cell shown (0 selects cell 0, 1 selects cell 1). rd_valid_o is that cell's valid bit, and rd_data_o is the stored stamp when the cell is valid and 0 when it is not.
- R8: A read-clear (rd_clear_i high at an edge) invalidates all cells, clears overflow_o and rewinds the pointer to cell 0. It has priority over a hit in the same cycle, which is then lost.
- R9: With test_mode_i at 1, a test_wr_i strobe writes test_data_i into every cell in one cycle and marks them all valid.
- R10: While test_mode_i is 1, discriminator edges record nothing and do not set overflow_o.
- R11: test_wr_i has no effect while test_mode_i is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| disc_i | input | 1 | Discriminator output; a rising level marks a hit |
| ts_bus_i | input | TS_W | Shared time-stamp bus |
| test_mode_i | input | 1 | Selects memory test mode |
| test_wr_i | input | 1 | Broadcast write strobe, used in test mode |
| test_data_i | input | TS_W | Value written to all cells by the test strobe |
| rd_sel_i | input | SEL_W | Cell shown on the read port |
| rd_clear_i | input | 1 | End-of-readout clear of the store |
| rd_data_o | output | TS_W | Selected cell's stamp, 0 when invalid |
| rd_valid_o | output | 1 | Selected cell holds a record |
| empty_o | output | 1 | No cell holds a record |
| overflow_o | output | 1 | Sticky: a hit was lost to a full store |

## Verification
The bench builds the block with its defaults: a 14-bit stamp and two cells. With two cells, the third hit of a sequence already meets a full store, so the overflow path and the sticky behaviour can be reached in a few strobes. Every cell index is reachable through the 1-bit select. The 14-bit width lets the test patterns all-ones, all-zeros and alternating bits reach the top bus bit. Together with a held pulse under a moving bus, these patterns expose slips in the capture edge or in the bit lanes.

// File: rtl/tsr_pkg.sv
package tsr_pkg;
  // Operation applied to the cell store in a given cycle, in priority order.
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_HIT   = 2'd1,
    OP_TEST  = 2'd2,
    OP_CLEAR = 2'd3
  } bank_op_e;
endpackage

// File: rtl/tsr_rst_sync.sv
module tsr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/tsr_edge_det.sv
module tsr_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  output logic rise_o
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;

  AST_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o); // R4
endmodule

// File: rtl/tsr_cell_bank.sv
module tsr_cell_bank
  import tsr_pkg::*;
#(
  parameter int TS_W  = 14,
  parameter int CELLS = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        hit_i,
  input  logic                        clear_i,
  input  logic                        test_mode_i,
  input  logic                        test_wr_i,
  input  logic [TS_W-1:0]             ts_i,
  input  logic [TS_W-1:0]             test_data_i,
  output logic [CELLS-1:0][TS_W-1:0]  cells_o,
  output logic [CELLS-1:0]            valid_o,
  output logic                        overflow_o
);
  localparam int PTR_W = $clog2(CELLS + 1);
  localparam logic [PTR_W-1:0] PTR_FULL = PTR_W'(CELLS);

  bank_op_e                    op;
  logic                        full;
  logic [PTR_W-1:0]            ptr_q, ptr_d;
  logic                        ovf_q, ovf_d;
  logic [CELLS-1:0]            valid_q, valid_d;
  logic [CELLS-1:0]            cell_we;
  logic [TS_W-1:0]             cell_wdata;
  logic [CELLS-1:0][TS_W-1:0]  cells_q;

  // Operation decode: clear beats test write beats hit.
  always_comb begin
    op = OP_IDLE;
    if (clear_i)                      op = OP_CLEAR;
    else if (test_mode_i) begin
      if (test_wr_i)                  op = OP_TEST;
    end
    else if (hit_i)                   op = OP_HIT;
  end

  assign full = (ptr_q == PTR_FULL);

  // Next-state logic.
  always_comb begin
    ptr_d      = ptr_q;
    ovf_d      = ovf_q;
    valid_d    = valid_q;
    cell_we    = '0;
    cell_wdata = ts_i;
    unique case (op)
      OP_CLEAR: begin
        ptr_d   = '0;
        ovf_d   = 1'b0;
        valid_d = '0;
      end
      OP_TEST: begin
        cell_we    = '1;
        cell_wdata = test_data_i;
        valid_d    = '1;
        ptr_d      = PTR_FULL;
      end
      OP_HIT: begin
        if (full) begin
          ovf_d = 1'b1;
        end else begin
          for (int i = 0; i < CELLS; i++) begin
            if (ptr_q == PTR_W'(i)) begin
              cell_we[i] = 1'b1;
              valid_d[i] = 1'b1;
            end
          end
          ptr_d = ptr_q + 1'b1;
        end
      end
      default: ;
    endcase
  end

  // Control registers.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q   <= '0;
      ovf_q   <= 1'b0;
      valid_q <= '0;
    end else begin
      ptr_q   <= ptr_d;
      ovf_q   <= ovf_d;
      valid_q <= valid_d;
    end
  end

  // Stamp storage, one enabled register per cell.
  for (genvar g = 0; g < CELLS; g++) begin : g_cell
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cells_q[g] <= '0;
      else if (cell_we[g]) cells_q[g] <= cell_wdata;
    end
  end

  assign cells_o    = cells_q;
  assign valid_o    = valid_q;
  assign overflow_o = ovf_q;

  AST_PTR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_q <= PTR_FULL); // R5
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !clear_i) |=> ovf_q); // R5
  AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_i && full && !test_mode_i && !clear_i) |=> $stable(cells_q)); // R5
  AST_TEST_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (test_mode_i && test_wr_i && !clear_i) |=> (valid_q == '1)); // R9
  AST_TEST_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (test_mode_i && !test_wr_i && !clear_i) |=> ($stable(cells_q) && $stable(ovf_q))); // R10
endmodule

// File: rtl/tsr_read_mux.sv
module tsr_read_mux #(
  parameter int TS_W  = 14,
  parameter int CELLS = 2,
  parameter int SEL_W = 1
) (
  input  logic [CELLS-1:0][TS_W-1:0] cells_i,
  input  logic [CELLS-1:0]           valid_i,
  input  logic [SEL_W-1:0]           sel_i,
  output logic [TS_W-1:0]            data_o,
  output logic                       valid_o,
  output logic                       empty_o
);
  always_comb begin
    data_o  = '0;
    valid_o = 1'b0;
    for (int i = 0; i < CELLS; i++) begin
      if (sel_i == SEL_W'(i) && valid_i[i]) begin
        data_o  = cells_i[i];
        valid_o = 1'b1;
      end
    end
  end

  assign empty_o = ~|valid_i;
endmodule

// File: rtl/ts_hit_recorder.sv
module ts_hit_recorder #(
  parameter int TS_W  = 14,
  parameter int CELLS = 2,
  localparam int SEL_W = (CELLS > 1) ? $clog2(CELLS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             disc_i,
  input  logic [TS_W-1:0]  ts_bus_i,
  input  logic             test_mode_i,
  input  logic             test_wr_i,
  input  logic [TS_W-1:0]  test_data_i,
  input  logic [SEL_W-1:0] rd_sel_i,
  input  logic             rd_clear_i,
  output logic [TS_W-1:0]  rd_data_o,
  output logic             rd_valid_o,
  output logic             empty_o,
  output logic             overflow_o
);
  logic                       rst_sync_n;
  logic                       hit;
  logic [CELLS-1:0][TS_W-1:0] cells;
  logic [CELLS-1:0]           valid;

  tsr_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  tsr_edge_det u_edge (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .lvl_i  (disc_i),
    .rise_o (hit)
  );

  tsr_cell_bank #(.TS_W(TS_W), .CELLS(CELLS)) u_bank (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .hit_i       (hit),
    .clear_i     (rd_clear_i),
    .test_mode_i (test_mode_i),
    .test_wr_i   (test_wr_i),
    .ts_i        (ts_bus_i),
    .test_data_i (test_data_i),
    .cells_o     (cells),
    .valid_o     (valid),
    .overflow_o  (overflow_o)
  );

  tsr_read_mux #(.TS_W(TS_W), .CELLS(CELLS), .SEL_W(SEL_W)) u_rd (
    .cells_i (cells),
    .valid_i (valid),
    .sel_i   (rd_sel_i),
    .data_o  (rd_data_o),
    .valid_o (rd_valid_o),
    .empty_o (empty_o)
  );

  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rd_clear_i |=> (empty_o && !overflow_o)); // R8
  AST_HIT_FILLS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (hit && !test_mode_i && !rd_clear_i) |=> !empty_o); // R2
  AST_CLEAR_NO_HIT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (hit && rd_clear_i) |=> empty_o); // R8
endmodule

// File: tb/ts_hit_recorder_tb.sv
module ts_hit_recorder_tb_top;
  localparam int TS_W  = 14;
  localparam int CELLS = 2;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            disc_i;
  logic [TS_W-1:0] ts_bus_i;
  logic            test_mode_i;
  logic            test_wr_i;
  logic [TS_W-1:0] test_data_i;
  logic [0:0]      rd_sel_i;
  logic            rd_clear_i;
  logic [TS_W-1:0] rd_data_o;
  logic            rd_valid_o;
  logic            empty_o;
  logic            overflow_o;

  int n_checks = 0;
  int n_fails  = 0;

  always #5 clk = ~clk;

  ts_hit_recorder #(.TS_W(TS_W), .CELLS(CELLS)) dut_i (
    .clk(clk), .rst_n(rst_n), .disc_i(disc_i), .ts_bus_i(ts_bus_i),
    .test_mode_i(test_mode_i), .test_wr_i(test_wr_i), .test_data_i(test_data_i),
    .rd_sel_i(rd_sel_i), .rd_clear_i(rd_clear_i), .rd_data_o(rd_data_o),
    .rd_valid_o(rd_valid_o), .empty_o(empty_o), .overflow_o(overflow_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // Check one cell through the read port (combinational path, sampled 1 ns after select).
  task automatic chk_cell(input string req, input int sel, input int vld, input int data);
    rd_sel_i = sel[0:0];
    #1;
    chk(req, $sformatf("cell%0d valid", sel), int'(rd_valid_o), vld);
    chk(req, $sformatf("cell%0d data", sel), int'(rd_data_o), data);
  endtask

  // One-cycle pulse of disc_i, driven at a falling edge; capture at the next rising edge.
  task automatic pulse_hit(input logic [TS_W-1:0] ts);
    @(negedge clk);
    disc_i   = 1'b1;
    ts_bus_i = ts;
    @(negedge clk);
    disc_i   = 1'b0;
    ts_bus_i = ~ts;
  endtask

  task automatic do_clear();
    @(negedge clk);
    rd_clear_i = 1'b1;
    @(negedge clk);
    rd_clear_i = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    disc_i = 1'b0; ts_bus_i = '0; test_mode_i = 1'b0; test_wr_i = 1'b0;
    test_data_i = '0; rd_sel_i = '0; rd_clear_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", "empty", int'(empty_o), 1);
    chk("R1", "overflow", int'(overflow_o), 0);
    chk_cell("R1", 0, 0, 0);
    chk_cell("R1", 1, 0, 0);
  endtask

  task automatic t_two_hits();
    pulse_hit(14'h1234);
    chk("R6", "empty after one hit", int'(empty_o), 0);
    chk_cell("R2", 0, 1, 'h1234);
    chk_cell("R7", 1, 0, 0);
    pulse_hit(14'h0ABC);
    chk_cell("R3", 1, 1, 'h0ABC);
    chk_cell("R3", 0, 1, 'h1234);
    chk("R5", "overflow before full hit", int'(overflow_o), 0);
  endtask

  task automatic t_overflow();
    pulse_hit(14'h3FFF);
    chk("R5", "overflow set", int'(overflow_o), 1);
    chk_cell("R5", 0, 1, 'h1234);
    chk_cell("R5", 1, 1, 'h0ABC);
    repeat (3) @(negedge clk);
    chk("R5", "overflow sticky", int'(overflow_o), 1);
  endtask

  task automatic t_clear();
    do_clear();
    chk("R8", "empty after clear", int'(empty_o), 1);
    chk("R8", "overflow after clear", int'(overflow_o), 0);
    chk("R6", "empty no records", int'(empty_o), 1);
    // Hit coincident with clear is lost.
    @(negedge clk);
    rd_clear_i = 1'b1; disc_i = 1'b1; ts_bus_i = 14'h0777;
    @(negedge clk);
    rd_clear_i = 1'b0;
    chk("R8", "hit lost under clear", int'(empty_o), 1);
    @(negedge clk);
    disc_i = 1'b0;
    pulse_hit(14'h0055);
    chk_cell("R8", 0, 1, 'h0055);
    chk_cell("R8", 1, 0, 0);
    do_clear();
  endtask

  task automatic t_long_pulse();
    @(negedge clk);
    disc_i = 1'b1; ts_bus_i = 14'h2AAA;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      ts_bus_i = ts_bus_i + 14'd1;
    end
    disc_i = 1'b0;
    @(negedge clk);
    chk_cell("R4", 0, 1, 'h2AAA);
    chk_cell("R4", 1, 0, 0);
    do_clear();
  endtask

  task automatic t_test_mode();
    // R11: strobe without test mode does nothing.
    @(negedge clk);
    test_wr_i = 1'b1; test_data_i = 14'h0003;
    @(negedge clk);
    test_wr_i = 1'b0;
    chk("R11", "empty after ignored strobe", int'(empty_o), 1);
    chk_cell("R11", 0, 0, 0);
    // R9 with two patterns.
    for (int p = 0; p < 2; p++) begin
      @(negedge clk);
      test_mode_i = 1'b1; test_wr_i = 1'b1;
      test_data_i = (p == 0) ? 14'h3FFF : 14'h0000;
      @(negedge clk);
      test_wr_i = 1'b0;
      chk("R9", "empty after broadcast", int'(empty_o), 0);
      chk_cell("R9", 0, 1, (p == 0) ? 'h3FFF : 'h0000);
      chk_cell("R9", 1, 1, (p == 0) ? 'h3FFF : 'h0000);
    end
    // R10: hits ignored in test mode.
    pulse_hit(14'h1111);
    pulse_hit(14'h2222);
    chk("R10", "overflow in test mode", int'(overflow_o), 0);
    chk_cell("R10", 0, 1, 0);
    chk_cell("R10", 1, 1, 0);
    @(negedge clk);
    test_mode_i = 1'b0;
    do_clear();
    chk("R8", "empty after test clear", int'(empty_o), 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    t_reset();
    t_two_hits();
    t_overflow();
    t_clear();
    t_long_pulse();
    t_test_mode();
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule